// File: doc/BRIEF.md
# Watermark-windowed receive FIFO

This block buffers 64-bit words that a serial flash engine reads from the device and hands them to a CPU through a small register port. The engine pushes one word per cycle whenever it has one. The CPU does not read data through a pop strobe. It sees the oldest chunk of data, sized by a programmable watermark, as a window of consecutive 32-bit registers. When it has read the window, it releases the whole chunk at once by writing 1 to the window-available flag.

The watermark field sets a chunk of (field+1) 64-bit entries. The default of 0 gives 8-byte chunks, which appear as two 32-bit registers. The engine marks its final word with an end indication. After that, a smaller remainder also counts as an available chunk, and the window registers that lie beyond it read as zero. A clear bit in the control register empties the buffer at once. A status register reports the fill level, a sticky overflow bit and a running count of the entries the CPU has released.

Top module: `rxw_fifo`

## Requirements
- R1: After reset the status register, the flag register, the control register and the window all read 0, and `win_avail_o` is 0.
- R2: Each accepted push adds one entry to the fill level. In the window, the 32-bit register at `0x40 + 8k` returns bits [31:0] of the chunk's entry k, and the one at `0x44 + 8k` returns bits [63:32].
- R3: Flag register `0x08` bit 0 and `win_avail_o` are 1 when the fill level is at least the chunk size.
- R4: A write to `0x08` with bit 0 set, made while the flag is 1, removes one chunk. The fill level drops by the chunk size (or by the remaining fill, see R6), and the window then shows the next entries.
- R5: Control register `0x00` bits [4:2] hold the watermark w, which sets a chunk of w+1 entries. Window registers at entry offsets w+1 and beyond, or at or beyond the fill level, read 0.
- R6: A push with `push_last_i` high marks end of data. While that mark is set and the fill level is non-zero but below the chunk size, the flag is 1, and a release removes all remaining entries. The mark is dropped once a release empties the buffer.
- R7: A write to `0x00` with bit 0 set empties the buffer by the next cycle. It also zeroes the overflow bit, the read counter and the end mark. Bit 0 always reads back 0.
- R8: Control bit 1 is stored and reads back as written. It has no effect on the data path.
- R9: Status register `0x04` holds the fill level in [6:0], the overflow bit in bit 15, and in [31:16] the count of released entries, which wraps.
- R10: A push while the buffer holds 64 entries is dropped and sets the sticky overflow bit. The stored data is left intact.
- R11: A release request while the flag is 0 changes nothing.
- R12: A write to `0x08` with bit 0 clear changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_valid_i | input | 1 | Engine pushes a word this cycle |
| push_data_i | input | 64 | Word from the engine |
| push_last_i | input | 1 | Pushed word is the last of the transfer |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| win_avail_o | output | 1 | Window-available flag, interrupt level |

## Verification
Most internal faults show up at the ports within one cycle. A read or write pointer that is off by one puts the wrong entry in window register `0x40` right after the next push or release. A wrong fill count shows up both in status bits [6:0] and in the flag, which then sets too early or too late around the watermark. The end mark and the overflow bit can only be seen later. A stale end mark shows as a flag that sets after a single push on a fresh transfer. An overflow that was not handled shows as the wrong word once the last chunk of a full buffer is released.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  localparam int unsigned REG_AW = 8;
  localparam logic [REG_AW-1:0] CTRL_ADDR = 8'h00;
  localparam logic [REG_AW-1:0] STAT_ADDR = 8'h04;
  localparam logic [REG_AW-1:0] FLAG_ADDR = 8'h08;
  localparam logic [REG_AW-1:0] WIN_BASE  = 8'h40;
  localparam int unsigned CTRL_CLR_BIT   = 0;
  localparam int unsigned CTRL_DMA_BIT   = 1;
  localparam int unsigned CTRL_WM_LSB    = 2;
  localparam int unsigned STAT_OVF_BIT   = 15;
  localparam int unsigned STAT_RDCNT_LSB = 16;
  localparam int unsigned RDCNT_W        = 16;
endpackage

// File: rtl/rxw_store.sv
module rxw_store #(
  parameter int unsigned DEPTH = 64,   // power of two
  parameter int unsigned DW    = 64,
  parameter int unsigned RC_W  = 16,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = PTR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic [DW-1:0]    push_data_i,
  input  logic             push_last_i,
  input  logic             pop_i,
  input  logic [CNT_W-1:0] pop_cnt_i,
  input  logic [PTR_W-1:0] rd_off_i,
  output logic [DW-1:0]    rd_data_o,
  output logic [CNT_W-1:0] fill_o,
  output logic             end_o,
  output logic             ovf_o,
  output logic [RC_W-1:0]  rd_cnt_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [DW-1:0]    mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] fill_q, fill_d, pop_amt;
  logic             end_q, ovf_q;
  logic [RC_W-1:0]  rd_cnt_q;
  logic             push_ok, pop_ok, full;

  assign full    = (fill_q == FULL);
  assign push_ok = push_i && !full && !clr_i;
  assign pop_ok  = pop_i && !clr_i;
  assign pop_amt = pop_ok ? pop_cnt_i : '0;
  assign fill_d  = fill_q + CNT_W'(push_ok) - pop_amt;

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      fill_q   <= '0;
      end_q    <= 1'b0;
      ovf_q    <= 1'b0;
      rd_cnt_q <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      fill_q   <= '0;
      end_q    <= 1'b0;
      ovf_q    <= 1'b0;
      rd_cnt_q <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop_ok) begin
        rd_ptr_q <= rd_ptr_q + PTR_W'(pop_cnt_i);
        rd_cnt_q <= rd_cnt_q + RC_W'(pop_cnt_i);
      end
      fill_q <= fill_d;
      if (push_i && full) ovf_q <= 1'b1;
      if (push_ok && push_last_i) end_q <= 1'b1;
      else if (pop_ok && fill_d == '0) end_q <= 1'b0;
    end
  end

  assign rd_data_o = mem_q[rd_ptr_q + rd_off_i];
  assign fill_o    = fill_q;
  assign end_o     = end_q;
  assign ovf_o     = ovf_q;
  assign rd_cnt_o  = rd_cnt_q;

  // R2
  push_adds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full && !pop_i && !clr_i) |=> fill_q == $past(fill_q) + 1'b1);
  // R4
  pop_drops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !clr_i) |=> fill_q == $past(fill_q) - $past(pop_cnt_i));
  // R10
  ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full && !clr_i) |=> ovf_q);
  // R10
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !clr_i) |=> ovf_q);
  // R10
  no_overfill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q <= FULL);
endmodule

// File: rtl/rxw_window.sv
module rxw_window #(
  parameter int unsigned WM_W  = 3,
  parameter int unsigned PTR_W = 6,
  localparam int unsigned CNT_W = PTR_W + 1,
  localparam int unsigned WIDX_W = WM_W + 1
) (
  input  logic [WIDX_W-1:0] word_idx_i,
  input  logic [CNT_W-1:0]  chunk_i,
  input  logic [CNT_W-1:0]  fill_i,
  input  logic [63:0]       entry_i,
  output logic [PTR_W-1:0]  ent_off_o,
  output logic [31:0]       word_o
);
  logic [WM_W-1:0] ent;
  logic            in_range;

  assign ent       = word_idx_i[WIDX_W-1:1];
  assign ent_off_o = PTR_W'(ent);
  // beyond the chunk or beyond stored data reads zero
  assign in_range  = (CNT_W'(ent) < chunk_i) && (CNT_W'(ent) < fill_i);
  assign word_o    = !in_range ? 32'h0 : (word_idx_i[0] ? entry_i[63:32] : entry_i[31:0]);
endmodule

// File: rtl/rxw_fifo.sv
module rxw_fifo
  import rxw_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned WM_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_valid_i,
  input  logic [63:0]       push_data_i,
  input  logic              push_last_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              win_avail_o
);
  localparam int unsigned PTR_W     = $clog2(DEPTH);
  localparam int unsigned CNT_W     = PTR_W + 1;
  localparam int unsigned WIN_WORDS = 2 << WM_W;
  localparam int unsigned WIN_BYTES = 4 * WIN_WORDS;
  localparam logic [REG_AW-1:0] WIN_HI = REG_AW'(int'(WIN_BASE) + WIN_BYTES - 1);

  logic            dma_q;
  logic [WM_W-1:0] wm_q;
  logic            ctrl_wr, clr, pop_req, pop, avail, win_hit;
  logic [CNT_W-1:0] chunk, fill, pop_cnt;
  logic            end_mark, ovf;
  logic [RDCNT_W-1:0] rd_cnt;
  logic [REG_AW-1:0] win_off;
  logic [PTR_W-1:0]  ent_off;
  logic [63:0]       entry;
  logic [31:0]       win_word, ctrl_rd, stat_rd;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata_i[31:CTRL_WM_LSB+WM_W];

  assign ctrl_wr = reg_we_i && (reg_addr_i == CTRL_ADDR);
  assign clr     = ctrl_wr && reg_wdata_i[CTRL_CLR_BIT];
  assign pop_req = reg_we_i && (reg_addr_i == FLAG_ADDR) && reg_wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dma_q <= 1'b0;
      wm_q  <= '0;
    end else if (ctrl_wr) begin
      dma_q <= reg_wdata_i[CTRL_DMA_BIT];
      wm_q  <= reg_wdata_i[CTRL_WM_LSB +: WM_W];
    end
  end

  assign chunk   = CNT_W'(wm_q) + 1'b1;
  assign avail   = (fill >= chunk) || (end_mark && fill != '0);
  assign pop     = pop_req && avail;
  assign pop_cnt = (fill >= chunk) ? chunk : fill;

  rxw_store #(.DEPTH(DEPTH), .DW(64), .RC_W(RDCNT_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr),
    .push_i      (push_valid_i),
    .push_data_i (push_data_i),
    .push_last_i (push_last_i),
    .pop_i       (pop),
    .pop_cnt_i   (pop_cnt),
    .rd_off_i    (ent_off),
    .rd_data_o   (entry),
    .fill_o      (fill),
    .end_o       (end_mark),
    .ovf_o       (ovf),
    .rd_cnt_o    (rd_cnt)
  );

  assign win_off = reg_addr_i - WIN_BASE;
  assign win_hit = (reg_addr_i >= WIN_BASE) && (reg_addr_i <= WIN_HI);

  rxw_window #(.WM_W(WM_W), .PTR_W(PTR_W)) u_window (
    .word_idx_i (win_off[2 +: WM_W+1]),
    .chunk_i    (chunk),
    .fill_i     (fill),
    .entry_i    (entry),
    .ent_off_o  (ent_off),
    .word_o     (win_word)
  );

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[CTRL_DMA_BIT] = dma_q;
    ctrl_rd[CTRL_WM_LSB +: WM_W] = wm_q;
    stat_rd = '0;
    stat_rd[CNT_W-1:0] = fill;
    stat_rd[STAT_OVF_BIT] = ovf;
    stat_rd[STAT_RDCNT_LSB +: RDCNT_W] = rd_cnt;
  end

  always_comb begin
    if (win_hit) reg_rdata_o = win_word;
    else begin
      unique case (reg_addr_i)
        CTRL_ADDR: reg_rdata_o = ctrl_rd;
        STAT_ADDR: reg_rdata_o = stat_rd;
        FLAG_ADDR: reg_rdata_o = {31'h0, avail};
        default:   reg_rdata_o = 32'h0;
      endcase
    end
  end

  assign win_avail_o = avail;

  // R7
  clear_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (fill == '0 && !ovf && rd_cnt == '0 && !win_avail_o));
  // R11
  idle_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_req && !avail && !push_valid_i && !clr) |=> $stable(fill));
  // R12
  zero_flag_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == FLAG_ADDR && !reg_wdata_i[0] && !push_valid_i) |=> $stable(fill));
  // R3
  flag_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill >= chunk) |-> win_avail_o);
endmodule

// File: tb/sim_rxw_fifo.sv
module sim_rxw_fifo;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        push_valid = 1'b0;
  logic [63:0] push_data = '0;
  logic        push_last = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        win_avail;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  rxw_fifo u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .push_valid_i(push_valid), .push_data_i(push_data), .push_last_i(push_last),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .win_avail_o(win_avail)
  );

  function automatic logic [63:0] pat(int n);
    return {16'hB00B, 16'(n), 16'h0FF0, 16'(n)};
  endfunction
  function automatic logic [31:0] lo(int n); return pat(n)[31:0]; endfunction
  function automatic logic [31:0] hi(int n); return pat(n)[63:32]; endfunction
  function automatic logic [31:0] stat(int fill, bit ovf, int rdc);
    return {16'(rdc), ovf, 8'h0, 7'(fill)};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(int n, bit last);
    @(negedge clk);
    push_valid = 1'b1; push_data = pat(n); push_last = last;
    @(negedge clk);
    push_valid = 1'b0; push_last = 1'b0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic t_reset();
    rd_chk("R1 status", 8'h04, 32'h0);
    rd_chk("R1 flag", 8'h08, 32'h0);
    rd_chk("R1 ctrl", 8'h00, 32'h0);
    rd_chk("R1 window", 8'h40, 32'h0);
    chk("R1 win_avail_o", {31'h0, win_avail}, 32'h0);
  endtask

  task automatic t_basic();
    push(1, 0); push(2, 0); push(3, 0);
    rd_chk("R9 fill 3", 8'h04, stat(3, 0, 0));
    rd_chk("R3 flag", 8'h08, 32'h1);
    rd_chk("R2 low word", 8'h40, lo(1));
    rd_chk("R2 high word", 8'h44, hi(1));
    rd_chk("R5 beyond chunk", 8'h48, 32'h0);
    wr(8'h08, 32'h1);
    rd_chk("R4 fill after pop", 8'h04, stat(2, 0, 1));
    rd_chk("R4 next chunk", 8'h40, lo(2));
    wr(8'h00, 32'h1);
    rd_chk("R7 cleared", 8'h04, 32'h0);
    rd_chk("R7 flag cleared", 8'h08, 32'h0);
  endtask

  task automatic t_wm();
    wr(8'h00, 32'h8);
    rd_chk("R5 ctrl readback", 8'h00, 32'h8);
    push(10, 0); push(11, 0);
    rd_chk("R5 below watermark", 8'h08, 32'h0);
    rd_chk("R5 entry1 low", 8'h48, lo(11));
    rd_chk("R5 unfilled entry", 8'h50, 32'h0);
    push(12, 0); push(13, 0);
    rd_chk("R5 at watermark", 8'h08, 32'h1);
    rd_chk("R5 entry2 high", 8'h54, hi(12));
    rd_chk("R5 entry past chunk", 8'h58, 32'h0);
    wr(8'h08, 32'h1);
    rd_chk("R4 chunk pop", 8'h04, stat(1, 0, 3));
    rd_chk("R4 window advance", 8'h40, lo(13));
    wr(8'h00, 32'h9);
  endtask

  task automatic t_end();
    push(20, 0); push(21, 1);
    rd_chk("R6 partial flag", 8'h08, 32'h1);
    rd_chk("R6 partial entry", 8'h48, lo(21));
    rd_chk("R6 unfilled zero", 8'h50, 32'h0);
    wr(8'h08, 32'h1);
    rd_chk("R6 remainder popped", 8'h04, stat(0, 0, 2));
    rd_chk("R6 flag drop", 8'h08, 32'h0);
    push(22, 0);
    rd_chk("R6 mark dropped", 8'h08, 32'h0);
    wr(8'h00, 32'h1);
  endtask

  task automatic t_ignore();
    wr(8'h08, 32'h1);
    rd_chk("R11 empty pop", 8'h04, 32'h0);
    push(30, 0);
    wr(8'h08, 32'hFFFF_FFFE);
    rd_chk("R12 zero bit write", 8'h04, stat(1, 0, 0));
    wr(8'h00, 32'h8);
    wr(8'h08, 32'h1);
    rd_chk("R11 below watermark pop", 8'h04, stat(1, 0, 0));
    rd_chk("R11 window intact", 8'h40, lo(30));
    wr(8'h00, 32'h1);
  endtask

  task automatic t_dma();
    wr(8'h00, 32'h2);
    rd_chk("R8 dma readback", 8'h00, 32'h2);
    push(40, 0);
    rd_chk("R8 data unaffected", 8'h40, lo(40));
    wr(8'h08, 32'h1);
    rd_chk("R8 pop unaffected", 8'h04, stat(0, 0, 1));
    wr(8'h00, 32'h1);
    rd_chk("R7 clear bit reads 0", 8'h00, 32'h0);
  endtask

  task automatic t_ovf();
    wr(8'h00, 32'h1C);
    for (int i = 0; i < 66; i++) push(100 + i, 0);
    rd_chk("R10 full with overflow", 8'h04, stat(64, 1, 0));
    rd_chk("R10 oldest kept", 8'h40, lo(100));
    rd_chk("R2 last window word", 8'h7C, hi(107));
    for (int k = 0; k < 7; k++) begin
      wr(8'h08, 32'h1);
      rd_chk("R4 chunk sequence", 8'h40, lo(108 + 8 * k));
    end
    rd_chk("R10 last entry not overwritten", 8'h7C, hi(163));
    wr(8'h08, 32'h1);
    rd_chk("R10 sticky after drain", 8'h04, stat(0, 1, 64));
    wr(8'h00, 32'h1);
    rd_chk("R7 overflow cleared", 8'h04, 32'h0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_wm();
    t_end();
    t_ignore();
    t_dma();
    t_ovf();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule